// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags and Branch Decision

This block is the execute-stage datapath of a small register-based processor. Each cycle it takes two 32-bit operands and an operation code and produces a 32-bit result without any register stage. It also drives a result-write qualifier and an illegal-rotate indication. The operations are add, subtract, signed multiply (low word), AND, OR, compare, increment, decrement, rotate right and rotate left.

Zero, sign and overflow flags come from the same result and go into a flag register. That register loads at the clock edge only when the caller enables a flag write and the operation is one that may write flags. A condition evaluator reads the stored flags and a 3-bit condition code and tells the sequencer whether a conditional jump is taken. Conditions cover equality, sign, overflow, signed less and signed greater, plus the negations of the first three. The result is ready within the execute cycle, and the flags are visible from the following edge.

Top module: `alu_cond_core`

## Requirements
- R1: With op 0 (add) or op 1 (subtract), result is the low 32 bits of A+B or A-B. The overflow flag written is signed two's-complement overflow, and res_wr is 1.
- R2: Op 5 (compare) computes A-B for the flags exactly as subtract does. It drives res_wr to 0.
- R3: Op 2 (multiply) returns the low 32 bits of the signed product of A and B. Overflow is written as 1 exactly when the signed 64-bit product does not fit in 32 signed bits.
- R4: Op 3 (AND) and op 4 (OR) return the bitwise result and always write the overflow flag as 0.
- R5: Op 6 (increment) and op 7 (decrement) return A+1 and A-1 with the same flag rules as add and subtract. Operand B has no effect on them.
- R6: Op 8 (rotate right) and op 9 (rotate left) rotate A by B when B is exactly 1, 8, 16 or 24, and write overflow as 0.
- R7: For a rotate with any other B, rot_bad is 1, result equals A, res_wr is 0 and the flags keep their value.
- R8: The zero flag is written as 1 exactly when the 32-bit result is all zeros. The sign flag is written as bit 31 of that result.
- R9: The flags reset to 0 and change only at a clock edge where flag_we is 1 and the op may write flags.
- R10: take_br is set from the stored flags by the condition code: 0 zero, 1 sign, 2 overflow, 3 sign XOR overflow (less), 4 sign equal to overflow with zero clear (greater), 5 not zero, 6 not sign, 7 not overflow.
- R11: Op codes 10 to 15 return A with res_wr 0 and rot_bad 0, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or rotate amount |
| flag_we | input | 1 | Flag write enable for this cycle |
| cond_sel | input | 3 | Branch condition code |
| result | output | 32 | Combinational result |
| res_wr | output | 1 | Result is meant to be written back |
| rot_bad | output | 1 | Rotate amount not allowed |
| zf_q | output | 1 | Stored zero flag |
| sf_q | output | 1 | Stored sign flag |
| of_q | output | 1 | Stored overflow flag |
| take_br | output | 1 | Branch-taken decision from stored flags |

## Verification
Add and subtract are tried with operand pairs that cross the signed limits in both directions, so real overflow can be told apart from plain carry-out. Compare runs on equal, lower and higher signed values so that each of the eight conditions gives both outcomes. Multiply is tried on a product that fits and on one that spills past 32 signed bits, and on a negative operand so that signed and unsigned treatment differ.

Rotates use each legal amount in both directions, plus illegal amounts whose result and flags must stay put. Disabled flag writes and undefined op codes follow an operation that would change the flags, so a missing hold shows up at the flag ports.

// File: rtl/alu_cond_core.sv
module alu_cond_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          flag_we,
  input  logic [2:0]    cond_sel,
  output logic [DW-1:0] result,
  output logic          res_wr,
  output logic          rot_bad,
  output logic          zf_q,
  output logic          sf_q,
  output logic          of_q,
  output logic          take_br
);
  localparam int PW = 2 * DW;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2,
                         OP_AND = 4'd3, OP_OR  = 4'd4, OP_CMP = 4'd5,
                         OP_INC = 4'd6, OP_DEC = 4'd7, OP_ROR = 4'd8,
                         OP_ROL = 4'd9;

  logic [DW-1:0] b_eff, sum, diff, rot_r, rot_l;
  logic [PW-1:0] prod;
  logic          ovf, fl_ok, amt_ok, use_one, is_sub;

  assign use_one = (op_sel == OP_INC) || (op_sel == OP_DEC);
  assign is_sub  = (op_sel == OP_SUB) || (op_sel == OP_CMP) || (op_sel == OP_DEC);
  assign b_eff   = use_one ? DW'(1) : opnd_b;
  assign sum     = opnd_a + b_eff;
  assign diff    = opnd_a - b_eff;
  assign prod    = PW'($signed(opnd_a) * $signed(opnd_b));
  assign amt_ok  = (opnd_b == DW'(1)) || (opnd_b == DW'(8)) ||
                   (opnd_b == DW'(16)) || (opnd_b == DW'(24));

  always_comb begin
    rot_r = opnd_a;
    rot_l = opnd_a;
    case (opnd_b)
      DW'(1):  begin rot_r = {opnd_a[0],     opnd_a[DW-1:1]};  rot_l = {opnd_a[DW-2:0],  opnd_a[DW-1]};     end
      DW'(8):  begin rot_r = {opnd_a[7:0],   opnd_a[DW-1:8]};  rot_l = {opnd_a[DW-9:0],  opnd_a[DW-1:DW-8]};  end
      DW'(16): begin rot_r = {opnd_a[15:0],  opnd_a[DW-1:16]}; rot_l = {opnd_a[DW-17:0], opnd_a[DW-1:DW-16]}; end
      DW'(24): begin rot_r = {opnd_a[23:0],  opnd_a[DW-1:24]}; rot_l = {opnd_a[DW-25:0], opnd_a[DW-1:DW-24]}; end
      default: ;
    endcase
  end

  always_comb begin
    result  = opnd_a;
    ovf     = 1'b0;
    res_wr  = 1'b1;
    fl_ok   = 1'b1;
    rot_bad = 1'b0;
    case (op_sel)
      OP_ADD, OP_INC: begin
        result = sum;
        ovf    = (opnd_a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != opnd_a[DW-1]);
      end
      OP_SUB, OP_DEC, OP_CMP: begin
        result = diff;
        ovf    = (opnd_a[DW-1] != b_eff[DW-1]) && (diff[DW-1] != opnd_a[DW-1]);
        res_wr = (op_sel != OP_CMP);
      end
      OP_MUL: begin
        result = prod[DW-1:0];
        ovf    = (prod[PW-1:DW-1] != '0) && (prod[PW-1:DW-1] != '1);
      end
      OP_AND: result = opnd_a & opnd_b;
      OP_OR:  result = opnd_a | opnd_b;
      OP_ROR, OP_ROL: begin
        rot_bad = !amt_ok;
        res_wr  = amt_ok;
        fl_ok   = amt_ok;
        if (amt_ok) result = (op_sel == OP_ROR) ? rot_r : rot_l;
      end
      default: begin
        res_wr = 1'b0;
        fl_ok  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zf_q <= 1'b0;
      sf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (flag_we && fl_ok) begin
      zf_q <= (result == '0);
      sf_q <= result[DW-1];
      of_q <= ovf;
    end
  end

  always_comb begin
    case (cond_sel)
      3'd0: take_br = zf_q;
      3'd1: take_br = sf_q;
      3'd2: take_br = of_q;
      3'd3: take_br = sf_q ^ of_q;
      3'd4: take_br = (sf_q == of_q) && !zf_q;
      3'd5: take_br = !zf_q;
      3'd6: take_br = !sf_q;
      default: take_br = !of_q;
    endcase
  end

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({zf_q, sf_q, of_q}));

  p_logic_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == OP_AND || op_sel == OP_OR)) |=> !of_q);

  p_bad_rot_keeps_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rot_bad |-> (result == opnd_a && !res_wr));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !rot_bad && op_sel < 4'd10 && result == '0) |=> zf_q);

  p_cmp_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |-> !res_wr);
endmodule

// File: tb/alu_cond_core_tb.sv
module alu_cond_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        flag_we = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic [31:0] result;
  logic        res_wr, rot_bad, zf_q, sf_q, of_q, take_br;

  typedef struct {
    logic [31:0] res;
    logic        wr, bad, z, s, o, tk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic mz = 0, ms = 0, mo = 0;

  always #2.5 clk = ~clk;

  alu_cond_core dut_i (.*);

  function automatic logic cond_ref(input logic [2:0] c, input logic z, s, o);
    case (c)
      3'd0: return z;
      3'd1: return s;
      3'd2: return o;
      3'd3: return s != o;
      3'd4: return (s == o) && !z;
      3'd5: return !z;
      3'd6: return !s;
      default: return !o;
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, b,
                       input logic we, input logic [2:0] c, input string tag);
    exp_t e;
    logic signed [63:0] p;
    logic [32:0] w;
    logic ov, ok, wr;
    logic [31:0] r;
    ok = 1; wr = 1; ov = 0; r = a;
    case (op)
      4'd0: begin r = a + b; ov = ($signed(a) + $signed(b)) != 64'($signed(r)); end
      4'd1, 4'd5: begin
        r = a - b;
        ov = (64'($signed(a)) - 64'($signed(b))) != 64'($signed(r));
        wr = (op == 4'd1);
      end
      4'd2: begin p = 64'($signed(a)) * 64'($signed(b)); r = p[31:0]; ov = p != 64'($signed(r)); end
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd6: begin r = a + 1; ov = (a == 32'h7fffffff); end
      4'd7: begin r = a - 1; ov = (a == 32'h80000000); end
      4'd8, 4'd9: begin
        if (b == 1 || b == 8 || b == 16 || b == 24) begin
          w = 0;
          r = (op == 4'd8) ? ((a >> b) | (a << (32 - b))) : ((a << b) | (a >> (32 - b)));
        end else begin ok = 0; wr = 0; end
      end
      default: begin ok = 0; wr = 0; end
    endcase
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; flag_we = we; cond_sel = c;
    if (we && ok) begin mz = (r == 0); ms = r[31]; mo = ov; end
    e.res = r; e.wr = wr; e.bad = (op == 4'd8 || op == 4'd9) && !ok;
    e.z = mz; e.s = ms; e.o = mo; e.tk = cond_ref(c, mz, ms, mo); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (result !== e.res || res_wr !== e.wr || rot_bad !== e.bad ||
            {zf_q, sf_q, of_q} !== {e.z, e.s, e.o} || take_br !== e.tk) begin
          n_bad++;
          $display("FAIL %s: got res=%h wr=%b bad=%b zso=%b%b%b tk=%b exp res=%h wr=%b bad=%b zso=%b%b%b tk=%b",
                   e.tag, result, res_wr, rot_bad, zf_q, sf_q, of_q, take_br,
                   e.res, e.wr, e.bad, e.z, e.s, e.o, e.tk);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if ({zf_q, sf_q, of_q} !== 3'b000) begin
      n_bad++; $display("FAIL R9 reset: got %b%b%b exp 000", zf_q, sf_q, of_q);
    end
    @(negedge clk); rst_n = 1'b1;
    drive(4'd0, 32'd5, 32'd7, 1, 3'd5, "R1 add plain");
    drive(4'd0, 32'h7fffffff, 32'd1, 1, 3'd2, "R1 add pos overflow");
    drive(4'd0, 32'hffffffff, 32'd1, 1, 3'd0, "R1 R8 add carry no overflow zero");
    drive(4'd1, 32'h80000000, 32'd1, 1, 3'd7, "R1 sub neg overflow");
    drive(4'd5, 32'd9, 32'd9, 1, 3'd0, "R2 cmp equal");
    drive(4'd5, 32'hfffffffe, 32'd3, 1, 3'd3, "R2 R10 cmp less");
    drive(4'd5, 32'd3, 32'hfffffffe, 1, 3'd4, "R2 R10 cmp greater");
    drive(4'd5, 32'd3, 32'hfffffffe, 0, 3'd6, "R10 not-sign");
    drive(4'd5, 32'h80000000, 32'd1, 1, 3'd3, "R10 less via overflow");
    drive(4'd2, 32'hfffffffd, 32'd7, 1, 3'd1, "R3 mul negative fits");
    drive(4'd2, 32'h00010000, 32'h00010000, 1, 3'd2, "R3 mul overflow");
    drive(4'd3, 32'hf0f0f0f0, 32'h0ff00ff0, 1, 3'd7, "R4 and");
    drive(4'd4, 32'h80000000, 32'h00000001, 1, 3'd1, "R4 R8 or sign");
    drive(4'd6, 32'h7fffffff, 32'hdeadbeef, 1, 3'd2, "R5 inc overflow b ignored");
    drive(4'd7, 32'd1, 32'h12345678, 1, 3'd0, "R5 dec to zero b ignored");
    drive(4'd8, 32'h12345678, 32'd8, 1, 3'd5, "R6 ror 8");
    drive(4'd8, 32'h00000001, 32'd1, 1, 3'd1, "R6 ror 1");
    drive(4'd9, 32'h12345678, 32'd24, 1, 3'd5, "R6 rol 24");
    drive(4'd9, 32'h80000001, 32'd16, 1, 3'd6, "R6 rol 16");
    drive(4'd2, 32'h40000000, 32'd4, 1, 3'd2, "R3 mul overflow again");
    drive(4'd8, 32'h0, 32'd4, 1, 3'd0, "R7 ror bad amount");
    drive(4'd9, 32'hcafef00d, 32'd0, 1, 3'd2, "R7 rol bad zero");
    drive(4'd0, 32'd0, 32'd0, 0, 3'd0, "R9 disabled write");
    drive(4'd12, 32'h00000000, 32'd1, 1, 3'd0, "R11 undefined op");
    drive(4'd15, 32'hffff0000, 32'd1, 1, 3'd5, "R11 undefined op 15");
    drive(4'd1, 32'd10, 32'd3, 1, 3'd4, "R1 sub plain greater");
    @(negedge clk);
    flag_we = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule